// File: doc/BRIEF.md
# Stereo Record-Path Automatic Level Controller

This block watches the stereo sample stream coming out of a record converter and trims a 6-bit input gain code whenever the signal runs hot. The user programs a target gain for each channel in half-decibel codes. While the controller is enabled, a sample whose magnitude on either channel lies above a programmable limit adds one half-decibel step to a shared gain reduction, at most once per attack hold-off window. Once the overload stops, each full recovery window of clean samples takes one step of reduction back off, until the applied gain again equals the programmed value. The applied gain is never higher than the programmed value.

Both channels use the same reduction amount, so a loud event on one side also lowers the other side and the stereo balance holds. Attack and recovery windows are counted in valid samples, with the sample rate given as a number of samples per millisecond. A single-cycle restart pulse zeroes the reduction and both timers whenever software touches the restart location. The current reduction is driven out so that software can read it back. With the controller disabled, the programmed gains go straight to the outputs.

Top module: `alc_gain_ctrl`

## Requirements
- R1: A target gain code above 48 (binary 110000, 24 dB) acts as 48. Codes 0 to 48 are used as they are, at 0.5 dB per code.
- R2: With `alc_en` low, the reduction is held at 0 from the next clock on, each gain output equals its saturated target, and overload samples have no effect.
- R3: A sample pair is an overload when the magnitude of either two's-complement channel is strictly greater than `limit_lvl`. A magnitude equal to the limit is not an overload. A value of -2^(SAMPLE_W-1) has magnitude 2^(SAMPLE_W-1).
- R4: An overload sample that arrives while the attack hold-off counter is zero raises the reduction by one and loads a hold-off of L-1 samples. L is SAMPLES_PER_MS times ATK_FAST_MS when `atk_sel`=0 and times ATK_SLOW_MS when `atk_sel`=1. Every valid sample decrements a non-zero hold-off. The reduction changes by at most one step per clock.
- R5: Every valid sample that is not an overload advances a recovery count. An overload sample clears the count. When the count reaches N-1 on a non-overload sample, the reduction drops by one and the count restarts. N is SAMPLES_PER_MS times 32, 64, 128 or 256 for `rec_sel` values 0, 1, 2 and 3.
- R6: Both channels share one reduction. Each gain output is max(saturated target − reduction, 0), so it never exceeds its target.
- R7: The reduction saturates at 48 and never goes below 0.
- R8: A high `restart` sets the reduction and both timers to 0 at the next edge, and it overrides a sample arriving in the same cycle.
- R9: `red_out` always shows the current reduction amount.
- R10: After reset the reduction and both timers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alc_en | input | 1 | Enables level control |
| restart | input | 1 | Single-cycle restart strobe |
| in_valid | input | 1 | A sample pair is present this cycle |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| limit_lvl | input | SAMPLE_W | Overload magnitude limit, unsigned |
| tgt_left | input | GAIN_W | Programmed left gain code |
| tgt_right | input | GAIN_W | Programmed right gain code |
| atk_sel | input | 1 | Attack hold-off select |
| rec_sel | input | 2 | Recovery window select |
| gain_left | output | GAIN_W | Applied left gain code |
| gain_right | output | GAIN_W | Applied right gain code |
| red_out | output | GAIN_W | Current gain reduction in codes |

## Verification
Recovery is the hardest behaviour to reach from the ports. A step back only happens after hundreds of consecutive clean samples, and any single overload in between throws that count away. Purely random samples almost never get there. The stimulus therefore alternates overload bursts of random length with long quiet stretches of random length, and changes the window selects between bursts. A directed sequence also walks one recovery window sample by sample so that its exact end, sample N-1 against sample N, is observed.

// File: rtl/alc_pkg.sv
package alc_pkg;
   localparam int REC_BASE_MS = 32;
   localparam int REC_SEL_W   = 2;

   typedef enum logic {
      ATK_FAST = 1'b0,
      ATK_SLOW = 1'b1
   } atk_mode_e;
endpackage

// File: rtl/alc_level_detect.sv
module alc_level_detect #(
   parameter int SAMPLE_W = 16,
   parameter int NUM_CH   = 2
) (
   input  logic [NUM_CH-1:0][SAMPLE_W-1:0] smp,
   input  logic [SAMPLE_W-1:0]             limit_lvl,
   output logic                            overload
);
   logic [NUM_CH-1:0] over_ch;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [SAMPLE_W-1:0] mag;
      always_comb begin
         mag        = smp[c][SAMPLE_W-1] ? (~smp[c] + 1'b1) : smp[c];
         over_ch[c] = mag > limit_lvl;
      end
   end

   assign overload = |over_ch;
endmodule

// File: rtl/alc_timer.sv
module alc_timer
   import alc_pkg::*;
#(
   parameter int SAMPLES_PER_MS = 48,
   parameter int ATK_FAST_MS    = 1,
   parameter int ATK_SLOW_MS    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 smp_valid,
   input  logic                 overload,
   input  atk_mode_e            atk_sel,
   input  logic [REC_SEL_W-1:0] rec_sel,
   output logic                 step_down,
   output logic                 step_up
);
   localparam int REC_MAX = 256 * SAMPLES_PER_MS;
   localparam int REC_W   = $clog2(REC_MAX);
   localparam int ATK_MAX = ATK_SLOW_MS * SAMPLES_PER_MS;
   localparam int ATK_W   = $clog2(ATK_MAX);

   if (ATK_FAST_MS * SAMPLES_PER_MS < 2) begin : g_bad_fast
      $error("alc_timer: fast attack window must span at least two samples");
   end
   if (ATK_SLOW_MS < ATK_FAST_MS) begin : g_bad_order
      $error("alc_timer: slow attack window shorter than fast one");
   end

   logic [ATK_W-1:0] atk_q, atk_d, atk_last;
   logic [REC_W-1:0] rec_q, rec_d, rec_last;

   always_comb begin
      atk_last = (atk_sel == ATK_SLOW) ? ATK_W'(ATK_SLOW_MS * SAMPLES_PER_MS - 1)
                                       : ATK_W'(ATK_FAST_MS * SAMPLES_PER_MS - 1);
      case (rec_sel)
         2'd0:    rec_last = REC_W'(REC_BASE_MS * SAMPLES_PER_MS - 1);
         2'd1:    rec_last = REC_W'(2 * REC_BASE_MS * SAMPLES_PER_MS - 1);
         2'd2:    rec_last = REC_W'(4 * REC_BASE_MS * SAMPLES_PER_MS - 1);
         default: rec_last = REC_W'(8 * REC_BASE_MS * SAMPLES_PER_MS - 1);
      endcase
   end

   assign step_down = smp_valid & overload & (atk_q == '0) & ~clr;
   assign step_up   = smp_valid & ~overload & (rec_q >= rec_last) & ~clr;

   always_comb begin
      atk_d = atk_q;
      rec_d = rec_q;
      if (clr) begin
         atk_d = '0;
         rec_d = '0;
      end else if (smp_valid) begin
         if (step_down)          atk_d = atk_last;
         else if (atk_q != '0)   atk_d = atk_q - 1'b1;
         if (overload || step_up) rec_d = '0;
         else                     rec_d = rec_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         atk_q <= '0;
         rec_q <= '0;
      end else begin
         atk_q <= atk_d;
         rec_q <= rec_d;
      end
   end

   AST_ATK_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      step_down |=> (atk_q != '0)); // R4
   AST_REC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rec_q) <= REC_MAX - 1); // R5
   AST_TIMERS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (atk_q == '0 && rec_q == '0)); // R8
endmodule

// File: rtl/alc_reduction.sv
module alc_reduction #(
   parameter int GAIN_W   = 6,
   parameter int MAX_CODE = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step_down,
   input  logic              step_up,
   output logic [GAIN_W-1:0] red
);
   if ((1 << GAIN_W) <= MAX_CODE) begin : g_bad_width
      $error("alc_reduction: GAIN_W too narrow for MAX_CODE");
   end

   logic [GAIN_W-1:0] red_q, red_d;

   always_comb begin
      red_d = red_q;
      if (clr)
         red_d = '0;
      else if (step_down && red_q < GAIN_W'(MAX_CODE))
         red_d = red_q + 1'b1;
      else if (step_up && red_q != '0)
         red_d = red_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) red_q <= '0;
      else        red_q <= red_d;
   end

   assign red = red_q;

   AST_RED_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
      int'(red_q) <= MAX_CODE); // R7
   AST_RED_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (int'(red_q) - int'($past(red_q)) <= 1 &&
                int'($past(red_q)) - int'(red_q) <= 1)); // R4
endmodule

// File: rtl/alc_gain_apply.sv
module alc_gain_apply #(
   parameter int GAIN_W   = 6,
   parameter int MAX_CODE = 48,
   parameter int NUM_CH   = 2
) (
   input  logic                          en,
   input  logic [GAIN_W-1:0]             red,
   input  logic [NUM_CH-1:0][GAIN_W-1:0] tgt,
   output logic [NUM_CH-1:0][GAIN_W-1:0] gain
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [GAIN_W-1:0] sat;
      always_comb begin
         sat = (tgt[c] > GAIN_W'(MAX_CODE)) ? GAIN_W'(MAX_CODE) : tgt[c];
         if (!en)
            gain[c] = sat;
         else
            gain[c] = (sat > red) ? (sat - red) : '0;
      end
   end
endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl
   import alc_pkg::*;
#(
   parameter int SAMPLE_W       = 16,
   parameter int GAIN_W         = 6,
   parameter int MAX_CODE       = 48,
   parameter int SAMPLES_PER_MS = 48,
   parameter int ATK_FAST_MS    = 1,
   parameter int ATK_SLOW_MS    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alc_en,
   input  logic                 restart,
   input  logic                 in_valid,
   input  logic [SAMPLE_W-1:0]  in_left,
   input  logic [SAMPLE_W-1:0]  in_right,
   input  logic [SAMPLE_W-1:0]  limit_lvl,
   input  logic [GAIN_W-1:0]    tgt_left,
   input  logic [GAIN_W-1:0]    tgt_right,
   input  logic                 atk_sel,
   input  logic [1:0]           rec_sel,
   output logic [GAIN_W-1:0]    gain_left,
   output logic [GAIN_W-1:0]    gain_right,
   output logic [GAIN_W-1:0]    red_out
);
   localparam int NUM_CH = 2;

   logic [NUM_CH-1:0][SAMPLE_W-1:0] smp;
   logic [NUM_CH-1:0][GAIN_W-1:0]   tgt, gain;
   logic                            overload, clr, step_down, step_up;
   logic [GAIN_W-1:0]               red;

   assign smp = {in_right, in_left};
   assign tgt = {tgt_right, tgt_left};
   assign clr = restart | ~alc_en;

   alc_level_detect #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) u_detect (
      .smp       (smp),
      .limit_lvl (limit_lvl),
      .overload  (overload)
   );

   alc_timer #(
      .SAMPLES_PER_MS (SAMPLES_PER_MS),
      .ATK_FAST_MS    (ATK_FAST_MS),
      .ATK_SLOW_MS    (ATK_SLOW_MS)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .smp_valid (in_valid),
      .overload  (overload),
      .atk_sel   (atk_mode_e'(atk_sel)),
      .rec_sel   (rec_sel),
      .step_down (step_down),
      .step_up   (step_up)
   );

   alc_reduction #(.GAIN_W(GAIN_W), .MAX_CODE(MAX_CODE)) u_red (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .step_down (step_down),
      .step_up   (step_up),
      .red       (red)
   );

   alc_gain_apply #(.GAIN_W(GAIN_W), .MAX_CODE(MAX_CODE), .NUM_CH(NUM_CH)) u_apply (
      .en   (alc_en),
      .red  (red),
      .tgt  (tgt),
      .gain (gain)
   );

   assign gain_left  = gain[0];
   assign gain_right = gain[1];
   assign red_out    = red;

   AST_RESTART_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (red_out == '0)); // R8
   AST_DISABLED_NO_CUT: assert property (@(posedge clk) disable iff (!rst_n)
      !alc_en |=> (red_out == '0)); // R2
   AST_GAIN_LE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_left <= tgt_left) && (gain_right <= tgt_right)); // R6
   AST_GAIN_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
      int'(gain_left) <= MAX_CODE && int'(gain_right) <= MAX_CODE); // R1
endmodule

// File: tb/tb_alc_gain_ctrl.sv
`timescale 1ns/1ps
module tb_alc_gain_ctrl;
   localparam int SW = 16, GW = 6, MAXC = 48, SPM = 2, AF = 1, AS = 4;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          alc_en = 1'b0, restart = 1'b0, in_valid = 1'b0, atk_sel = 1'b0;
   logic [SW-1:0] in_left = '0, in_right = '0, limit_lvl = 16'd1000;
   logic [GW-1:0] tgt_left = 6'd20, tgt_right = 6'd60;
   logic [1:0]    rec_sel = 2'd0;
   logic [GW-1:0] gain_left, gain_right, red_out;

   int n_chk = 0, n_bad = 0;
   int m_red = 0, m_atk = 0, m_rec = 0;

   always #10 clk = ~clk;

   alc_gain_ctrl #(.SAMPLE_W(SW), .GAIN_W(GW), .MAX_CODE(MAXC),
                   .SAMPLES_PER_MS(SPM), .ATK_FAST_MS(AF), .ATK_SLOW_MS(AS)) dut (
      .clk(clk), .rst_n(rst_n), .alc_en(alc_en), .restart(restart),
      .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
      .limit_lvl(limit_lvl), .tgt_left(tgt_left), .tgt_right(tgt_right),
      .atk_sel(atk_sel), .rec_sel(rec_sel),
      .gain_left(gain_left), .gain_right(gain_right), .red_out(red_out));

   function automatic int satc(int c);
      return (c > MAXC) ? MAXC : c;
   endfunction
   function automatic int exp_gain(int t);
      int s = satc(t);
      if (!alc_en) return s;
      return (s > m_red) ? s - m_red : 0;
   endfunction
   function automatic int mag(logic [SW-1:0] v);
      return v[SW-1] ? (1 << SW) - int'(v) : int'(v);
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all(string req);
      check(req, int'(red_out), m_red);            // R9 reported reduction
      check(req, int'(gain_left), exp_gain(int'(tgt_left)));
      check(req, int'(gain_right), exp_gain(int'(tgt_right)));
   endtask

   task automatic send(int l, int r, string req);
      bit ovl;
      int alen, rlen;
      @(negedge clk);
      in_left = SW'(l); in_right = SW'(r); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      ovl  = (mag(in_left) > int'(limit_lvl)) || (mag(in_right) > int'(limit_lvl));
      alen = (atk_sel ? AS : AF) * SPM;
      rlen = (32 << rec_sel) * SPM;
      if (alc_en) begin
         if (ovl) begin
            m_rec = 0;
            if (m_atk == 0) begin
               if (m_red < MAXC) m_red++;
               m_atk = alen - 1;
            end else m_atk--;
         end else begin
            if (m_atk > 0) m_atk--;
            if (m_rec >= rlen - 1) begin
               if (m_red > 0) m_red--;
               m_rec = 0;
            end else m_rec++;
         end
      end
      check_all(req);
   endtask

   task automatic do_restart();
      @(negedge clk); restart = 1'b1;
      @(negedge clk); restart = 1'b0;
      m_red = 0; m_atk = 0; m_rec = 0;
      check_all("R8");
   endtask

   task automatic set_en(bit e);
      @(negedge clk); alc_en = e;
      if (!e) begin m_red = 0; m_atk = 0; m_rec = 0; end
      @(negedge clk);
      check_all("R2");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state, R1 saturation of code 60 to 48
      check("R10", int'(red_out), 0);
      check("R1", int'(gain_left), 20);
      check("R1", int'(gain_right), 48);

      tgt_left = 6'd30; tgt_right = 6'd10;
      set_en(1'b1);
      send(1000, -1000, "R3");              // equal to limit: no overload
      check("R3", int'(red_out), 0);
      send(-1001, 0, "R4");                 // first overload step
      check("R4", int'(gain_left), 29);
      send(0, 1001, "R4");                  // inside hold-off
      check("R4", int'(red_out), 1);
      send(0, -32768, "R3");                // most negative value overloads
      check("R4", int'(red_out), 2);
      // R5: 63 clean samples keep reduction, the 64th takes one step back
      for (int i = 0; i < 63; i++) send(5, -5, "R5");
      check("R5", int'(red_out), 2);
      send(5, -5, "R5");
      check("R5", int'(red_out), 1);
      // R5: an overload in mid-window restarts the recovery count
      for (int i = 0; i < 40; i++) send(0, 0, "R5");
      send(2000, 0, "R5");
      for (int i = 0; i < 63; i++) send(0, 0, "R5");
      check("R5", int'(red_out), 2);
      // R7 saturation at 48, R6 gains floor at 0
      tgt_left = 6'd63; tgt_right = 6'd40;
      for (int i = 0; i < 110; i++) send(3000, 3000, "R7");
      check("R7", int'(red_out), 48);
      check("R6", int'(gain_right), 0);
      // R8 restart, also with a sample in the same cycle
      do_restart();
      @(negedge clk); restart = 1'b1; in_valid = 1'b1; in_left = 16'd5000;
      @(negedge clk); restart = 1'b0; in_valid = 1'b0;
      check("R8", int'(red_out), 0);
      // R2 disabled: overloads ignored, pass-through
      set_en(1'b0);
      for (int i = 0; i < 5; i++) send(9000, 9000, "R2");
      check("R2", int'(gain_left), 48);
      set_en(1'b1);
      // R4 slow attack window
      atk_sel = 1'b1;
      for (int i = 0; i < 30; i++) send(-4000, 0, "R4");
      // R5 longest window
      rec_sel = 2'd3;
      for (int i = 0; i < 520; i++) send(1, 1, "R5");
      // random bursts, R6
      for (int b = 0; b < 24; b++) begin
         int nov = $urandom_range(0, 12);
         int nq  = $urandom_range(0, 300);
         atk_sel = 1'($urandom_range(0, 1));
         rec_sel = 2'($urandom_range(0, 3));
         tgt_left  = 6'($urandom_range(0, 63));
         tgt_right = 6'($urandom_range(0, 63));
         for (int i = 0; i < nov; i++) begin
            int a = $urandom_range(1001, 32767);
            if ($urandom_range(0, 1) == 1) send(-a, $urandom_range(0, 1000), "R6");
            else send($urandom_range(0, 1000), a, "R6");
         end
         for (int i = 0; i < nq; i++) send(int'($urandom_range(0, 2000)) - 1000, 1000, "R6");
         if (b == 12) do_restart();
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule